// File: doc/BRIEF.md
# Flash Burst-Mode Read Engine

This block is the read side of a NOR-style flash that offers a clocked burst read next to its ordinary asynchronous read. After power-up it behaves as a plain array: the data output follows the address input with no clock involved. A decoded enable pulse makes burst mode active, and the mode stays active until one of three things happens: a decoded disable pulse, a hardware reset, or a power-down request. The software reset command does not end burst mode. While burst mode is active, a clocked load strobe captures a starting word address. A fixed number of clock edges later, the first word appears. From then on, each clock edge with the advance strobe low steps to the next word inside an aligned block of `BLEN` words.

An active-low last-word flag marks the final word of each block-length burst. The offset counter wraps within the aligned block, so holding the advance strobe low past the end starts the same block again. The flash array is a behavioural model whose contents are computed from the address. Programming, erase and command decoding are not part of this block.

Top module: `flash_burst_reader`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `burst_active` is 0, `word_vld` is 0 and `last_n` is 1.
- R2: A one-cycle `cmd_burst_on` pulse, with no disable or power-down in the same cycle, sets `burst_active` at that clock edge. Further enable pulses leave it at 1.
- R3: In burst mode, a clock edge with `ld_n` low captures `addr` as the load edge. If the very next edge also sees `ld_n` low, no burst starts: `word_vld` stays 0 until `ld_n` returns high and a fresh load edge occurs.
- R4: After a good load, `word_vld` stays 0 for the first `LAT-1` edges after the load edge. It rises with the `LAT`-th edge, and `dout` then shows the word at the loaded address.
- R5: While a word is shown, each edge with `adv_n` low and `ld_n` high moves to address `{upper bits, (low log2(BLEN) bits + 1) mod BLEN}`. An edge with `adv_n` high keeps `dout` unchanged. `addr` is ignored during the burst.
- R6: `last_n` is 0 exactly while the `BLEN`-th word of a burst is shown, which is after `BLEN-1` advances. A further advance wraps to the first word of the block and sets `last_n` back to 1.
- R7: An edge with `ld_n` low while a burst is waiting or streaming starts a new load. `word_vld` goes to 0 and `last_n` to 1 at that edge.
- R8: A `cmd_soft_reset` pulse leaves `burst_active` unchanged and drops any burst in progress (`word_vld` 0 after that edge). A later load works normally.
- R9: Any of the following clears `burst_active`: `cmd_burst_off` high at an edge, `pwr_dn` high at an edge, or `rst_n` going low (asynchronous).
- R10: When no burst word is shown, `dout` is the combinational array word at `addr`. The array word for address a is bits [31:16] of ((a * 0x9E3779B1) mod 2^32) XOR 0x5A5AC3C3, for `DW`=16. With burst mode off, `ld_n` and `adv_n` are ignored: `word_vld` stays 0 and `last_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| pwr_dn | input | 1 | Power-down request; leaves burst mode |
| cmd_burst_on | input | 1 | Decoded burst-enable command pulse |
| cmd_burst_off | input | 1 | Decoded burst-disable command pulse |
| cmd_soft_reset | input | 1 | Decoded software reset command pulse |
| addr | input | AW | Word address |
| ld_n | input | 1 | Load-address strobe, active low |
| adv_n | input | 1 | Burst-advance strobe, active low |
| dout | output | DW | Read data |
| word_vld | output | 1 | A burst word is being shown on `dout` |
| last_n | output | 1 | Last word of a burst, active low |
| burst_active | output | 1 | Burst mode is entered |

## Verification
A wrong mode flag shows up at once. `burst_active` disagrees, and a load strobe either starts a burst that should not start or fails to start one. A latency counter that is off by one makes `word_vld` rise one edge early or late, and the first data compare fails in that same cycle. An offset error shows up as a wrong `dout` on the very next advance. A wrong last-word decode shows up as `last_n` low on the wrong word within one block length.

// File: rtl/flash_burst_pkg.sv
package flash_burst_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_WAIT,
    SQ_STREAM,
    SQ_ABORT
  } seq_state_t;

  localparam logic [31:0] HASH_MUL = 32'h9E37_79B1;
  localparam logic [31:0] HASH_XOR = 32'h5A5A_C3C3;

  // Behavioural array contents: a multiplicative hash of the word address.
  function automatic logic [31:0] array_hash(input logic [31:0] a);
    array_hash = (a * HASH_MUL) ^ HASH_XOR;
  endfunction

endpackage

// File: rtl/burst_mode_ctl.sv
module burst_mode_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic en_pulse,
  input  logic dis_pulse,
  output logic mode,
  output logic exit_evt
);

  logic mode_q;
  logic leave_req;

  // Leaving has priority over entering; the soft reset command is not an input.
  assign leave_req = pwr_dn | dis_pulse;
  assign exit_evt  = mode_q & leave_req;
  assign mode      = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (leave_req) begin
      mode_q <= 1'b0;
    end else if (en_pulse) begin
      mode_q <= 1'b1;
    end
  end

endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import flash_burst_pkg::*;
#(
  parameter int AW   = 10,
  parameter int LAT  = 3,
  parameter int BLEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          kill,
  input  logic          ld_n,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  output logic          word_vld,
  output logic          last_n,
  output logic [AW-1:0] cur_addr,
  output logic          load_evt,
  output logic          abort_evt,
  output logic          step_evt
);

  localparam int OFS_W = $clog2(BLEN);
  localparam int CW    = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0]    LAT_END  = CW'(LAT - 1);
  localparam logic [OFS_W-1:0] OFS_LAST = OFS_W'(BLEN - 1);

  seq_state_t       state_q;
  logic [AW-1:0]    base_q;
  logic [OFS_W-1:0] ofs_q;
  logic [CW-1:0]    lat_q;
  logic             lat_done;
  logic             in_latency;

  // Address inside the aligned block: upper bits fixed, low bits wrap.
  function automatic logic [AW-1:0] block_addr(input logic [AW-1:0] base,
                                               input logic [OFS_W-1:0] ofs);
    logic [OFS_W-1:0] low;
    low = base[OFS_W-1:0] + ofs;
    block_addr = {base[AW-1:OFS_W], low};
  endfunction

  assign in_latency = (state_q == SQ_LOAD) || (state_q == SQ_WAIT);
  assign lat_done   = (lat_q == LAT_END);

  // A load edge: strobe low, burst mode on, not the check edge right after a load.
  assign load_evt  = mode && !kill && !ld_n &&
                     (state_q != SQ_LOAD) && (state_q != SQ_ABORT);
  assign abort_evt = mode && !kill && !ld_n && (state_q == SQ_LOAD);
  assign step_evt  = !kill && ld_n && !adv_n && (state_q == SQ_STREAM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      base_q  <= '0;
      ofs_q   <= '0;
      lat_q   <= '0;
    end else if (kill) begin
      state_q <= SQ_IDLE;
    end else if (load_evt) begin
      state_q <= SQ_LOAD;
      base_q  <= addr;
      ofs_q   <= '0;
      lat_q   <= '0;
    end else begin
      case (state_q)
        SQ_LOAD: begin
          if (!ld_n) begin
            state_q <= SQ_ABORT;
          end else if (lat_done) begin
            state_q <= SQ_STREAM;
          end else begin
            lat_q   <= lat_q + 1'b1;
            state_q <= SQ_WAIT;
          end
        end
        SQ_WAIT: begin
          if (lat_done) begin
            state_q <= SQ_STREAM;
          end else begin
            lat_q <= lat_q + 1'b1;
          end
        end
        SQ_STREAM: begin
          if (step_evt) begin
            ofs_q <= ofs_q + 1'b1;
          end
        end
        SQ_ABORT: begin
          if (ld_n) begin
            state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign word_vld = (state_q == SQ_STREAM) && !in_latency;
  assign last_n   = !((state_q == SQ_STREAM) && (ofs_q == OFS_LAST));
  assign cur_addr = block_addr(base_q, ofs_q);

endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
  import flash_burst_pkg::*;
#(
  parameter int AW    = 10,
  parameter int DW    = 16,
  parameter int NPORT = 2
) (
  input  logic [NPORT*AW-1:0] rd_addr,
  output logic [NPORT*DW-1:0] rd_data
);

  localparam int SHIFT = 32 - DW;

  // Every read port is an independent combinational lookup of the same contents.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign rd_data[p*DW +: DW] =
      DW'(array_hash(32'(rd_addr[p*AW +: AW])) >> SHIFT);
  end

endmodule

// File: rtl/flash_burst_reader.sv
module flash_burst_reader
  import flash_burst_pkg::*;
#(
  parameter int AW   = 10,
  parameter int DW   = 16,
  parameter int LAT  = 3,
  parameter int BLEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_dn,
  input  logic          cmd_burst_on,
  input  logic          cmd_burst_off,
  input  logic          cmd_soft_reset,
  input  logic [AW-1:0] addr,
  input  logic          ld_n,
  input  logic          adv_n,
  output logic [DW-1:0] dout,
  output logic          word_vld,
  output logic          last_n,
  output logic          burst_active
);

  localparam int RD_PORTS = 2;

  logic            mode;
  logic            exit_evt;
  logic            seq_kill;
  logic            load_evt;
  logic            abort_evt;
  logic            step_evt;
  logic [AW-1:0]   cur_addr;
  logic [DW-1:0]   async_word;
  logic [DW-1:0]   burst_word;
  logic [RD_PORTS*AW-1:0] rd_addr;
  logic [RD_PORTS*DW-1:0] rd_data;

  burst_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn    (pwr_dn),
    .en_pulse  (cmd_burst_on),
    .dis_pulse (cmd_burst_off),
    .mode      (mode),
    .exit_evt  (exit_evt)
  );

  // The soft reset command drops the burst in progress but not the mode.
  assign seq_kill = exit_evt | cmd_soft_reset;

  burst_seq #(.AW(AW), .LAT(LAT), .BLEN(BLEN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .kill      (seq_kill),
    .ld_n      (ld_n),
    .adv_n     (adv_n),
    .addr      (addr),
    .word_vld  (word_vld),
    .last_n    (last_n),
    .cur_addr  (cur_addr),
    .load_evt  (load_evt),
    .abort_evt (abort_evt),
    .step_evt  (step_evt)
  );

  assign rd_addr = {cur_addr, addr};

  flash_array_model #(.AW(AW), .DW(DW), .NPORT(RD_PORTS)) u_array (
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  assign async_word   = rd_data[0 +: DW];
  assign burst_word   = rd_data[DW +: DW];
  assign dout         = word_vld ? burst_word : async_word;
  assign burst_active = mode;

endmodule

// File: rtl/flash_burst_reader_chk.sv
module flash_burst_reader_chk #(
  parameter int AW   = 10,
  parameter int DW   = 16,
  parameter int LAT  = 3,
  parameter int BLEN = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_dn,
  input logic          cmd_burst_on,
  input logic          cmd_burst_off,
  input logic          cmd_soft_reset,
  input logic          ld_n,
  input logic          adv_n,
  input logic [DW-1:0] dout,
  input logic          word_vld,
  input logic          last_n,
  input logic          burst_active,
  input logic          load_evt,
  input logic          abort_evt,
  input logic          step_evt,
  input logic [AW-1:0] cur_addr
);

  localparam int SLW = $clog2(LAT + 1) + 1;
  localparam logic [SLW-1:0] SAT = '1;
  localparam logic [AW-1:0]  LOW_MASK = AW'(BLEN - 1);

  logic [SLW-1:0] since_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_load <= SAT;
    end else if (load_evt) begin
      since_load <= '0;
    end else if (since_load != SAT) begin
      since_load <= since_load + 1'b1;
    end
  end

  function automatic logic [AW-1:0] succ(input logic [AW-1:0] a);
    succ = (a & ~LOW_MASK) | ((a + AW'(1)) & LOW_MASK);
  endfunction

  AST_ON_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_burst_on && !cmd_burst_off && !pwr_dn |=> burst_active); // R2
  AST_ABORT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !word_vld); // R3
  AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_vld) |-> since_load == SLW'(LAT)); // R4
  AST_STEP_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> word_vld && cur_addr == succ($past(cur_addr))); // R5
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld && adv_n && ld_n && !cmd_soft_reset && !cmd_burst_off && !pwr_dn
    |=> $stable(dout)); // R5
  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    !last_n |-> word_vld); // R6
  AST_RELOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> last_n && !word_vld); // R7
  AST_SOFT_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_soft_reset && burst_active && !cmd_burst_off && !pwr_dn
    |=> burst_active && !word_vld); // R8
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_burst_off || pwr_dn |=> !burst_active); // R9
  AST_OFF_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active |-> !word_vld && last_n); // R10

endmodule

bind flash_burst_reader flash_burst_reader_chk #(
  .AW(AW), .DW(DW), .LAT(LAT), .BLEN(BLEN)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pwr_dn         (pwr_dn),
  .cmd_burst_on   (cmd_burst_on),
  .cmd_burst_off  (cmd_burst_off),
  .cmd_soft_reset (cmd_soft_reset),
  .ld_n           (ld_n),
  .adv_n          (adv_n),
  .dout           (dout),
  .word_vld       (word_vld),
  .last_n         (last_n),
  .burst_active   (burst_active),
  .load_evt       (load_evt),
  .abort_evt      (abort_evt),
  .step_evt       (step_evt),
  .cur_addr       (cur_addr)
);

// File: tb/flash_burst_reader_test.sv
module flash_burst_reader_test;
  localparam int AW   = 10;
  localparam int DW   = 16;
  localparam int LAT  = 3;
  localparam int BLEN = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, pwr_dn, cmd_burst_on, cmd_burst_off, cmd_soft_reset;
  logic          ld_n, adv_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dout;
  logic          word_vld, last_n, burst_active;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  flash_burst_reader #(.AW(AW), .DW(DW), .LAT(LAT), .BLEN(BLEN)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .cmd_burst_on(cmd_burst_on),
    .cmd_burst_off(cmd_burst_off), .cmd_soft_reset(cmd_soft_reset),
    .addr(addr), .ld_n(ld_n), .adv_n(adv_n), .dout(dout),
    .word_vld(word_vld), .last_n(last_n), .burst_active(burst_active)
  );

  function automatic longint exp_word(int a);
    longint p;
    p = (longint'(a) * 64'd2654435761) & 64'hFFFF_FFFF;
    p = p ^ 64'h5A5A_C3C3;
    return (p >> 16) & 64'hFFFF;
  endfunction

  function automatic int blk(int s, int i);
    return (s & ~(BLEN - 1)) | ((s + i) & (BLEN - 1));
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic enable_burst();
    cmd_burst_on = 1'b1;
    @(negedge clk);
    cmd_burst_on = 1'b0;
  endtask

  // Load s, wait the latency, then ncyc cycles of advance (optionally stalled).
  task automatic run_burst(int s, int ncyc, bit stall);
    int idx;
    bit a_n;
    addr = AW'(s); ld_n = 1'b0; adv_n = 1'b1;
    @(negedge clk);
    ld_n = 1'b1;
    addr = AW'(s ^ 'h2AA);
    chk("R7 last_n high after load edge", longint'(last_n), 1);
    chk("R4 no word at load edge", longint'(word_vld), 0);
    for (int k = 1; k < LAT; k++) begin
      @(negedge clk);
      chk("R4 no word during latency", longint'(word_vld), 0);
    end
    @(negedge clk);
    chk("R4 word valid at latency end", longint'(word_vld), 1);
    chk("R4 first word", longint'(dout), exp_word(blk(s, 0)));
    chk("R6 first word not last", longint'(last_n), 1);
    idx = 0;
    for (int c = 0; c < ncyc; c++) begin
      a_n = stall ? (((c * 7) % 5) < 2) : 1'b0;
      adv_n = a_n;
      @(negedge clk);
      if (!a_n) idx++;
      chk("R5 burst word", longint'(dout), exp_word(blk(s, idx)));
      chk("R6 last flag", longint'(last_n), ((idx % BLEN) == BLEN - 1) ? 0 : 1);
    end
    adv_n = 1'b1;
    @(negedge clk);
    chk("R5 hold with advance high", longint'(dout), exp_word(blk(s, idx)));
    chk("R5 still valid on hold", longint'(word_vld), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwr_dn = 1'b0; cmd_burst_on = 1'b0; cmd_burst_off = 1'b0;
    cmd_soft_reset = 1'b0; ld_n = 1'b1; adv_n = 1'b1; addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 mode off in reset", longint'(burst_active), 0);
    chk("R1 no word in reset", longint'(word_vld), 0);
    chk("R1 last_n high in reset", longint'(last_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode off after reset", longint'(burst_active), 0);

    // R10: async sweep of the full array with strobes toggling
    for (int a = 0; a < (1 << AW); a++) begin
      addr = AW'(a); ld_n = a[0]; adv_n = a[1];
      @(negedge clk);
      chk("R10 async word", longint'(dout), exp_word(a));
      if ((a % 64) == 0) begin
        chk("R10 strobes ignored, no word", longint'(word_vld), 0);
        chk("R10 strobes ignored, last_n", longint'(last_n), 1);
      end
    end
    ld_n = 1'b1; adv_n = 1'b1;

    // R2: enter burst mode, repeat enable
    enable_burst();
    chk("R2 mode entered", longint'(burst_active), 1);
    @(negedge clk);
    chk("R2 mode sticky", longint'(burst_active), 1);
    enable_burst();
    chk("R2 repeated enable", longint'(burst_active), 1);
    chk("R2 no word without load", longint'(word_vld), 0);

    // R4 R5 R6: sweep of start addresses with one wrap
    for (int s = 0; s < (1 << AW); s += 11) run_burst(s, BLEN + 1, 1'b0);
    run_burst(100, 70, 1'b1);

    // R3: load strobe held for two edges
    addr = AW'(200); ld_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ld_n = 1'b1;
    chk("R3 aborted, no word", longint'(word_vld), 0);
    for (int k = 0; k < LAT + 3; k++) begin
      @(negedge clk);
      chk("R3 aborted burst stays idle", longint'(word_vld), 0);
    end
    run_burst(200, 3, 1'b0);

    // R7: reload while the last word is shown
    run_burst(300, BLEN - 1, 1'b0);
    chk("R6 last word held", longint'(last_n), 0);
    run_burst(500, 4, 1'b0);

    // R8: soft reset keeps burst mode
    run_burst(600, 5, 1'b0);
    cmd_soft_reset = 1'b1;
    @(negedge clk);
    cmd_soft_reset = 1'b0;
    chk("R8 mode kept", longint'(burst_active), 1);
    chk("R8 burst dropped", longint'(word_vld), 0);
    chk("R8 last_n high", longint'(last_n), 1);
    run_burst(601, BLEN + 2, 1'b0);

    // R9 + R10: disable command, then strobes ignored
    cmd_burst_off = 1'b1;
    @(negedge clk);
    cmd_burst_off = 1'b0;
    chk("R9 disable leaves mode", longint'(burst_active), 0);
    addr = AW'(77); ld_n = 1'b0;
    @(negedge clk);
    ld_n = 1'b1; adv_n = 1'b0;
    for (int k = 0; k < LAT + 3; k++) begin
      @(negedge clk);
      chk("R10 no burst when off", longint'(word_vld), 0);
      chk("R10 async word when off", longint'(dout), exp_word(77));
    end
    adv_n = 1'b1;

    // R9: power-down
    enable_burst();
    run_burst(900, 3, 1'b0);
    pwr_dn = 1'b1;
    @(negedge clk);
    pwr_dn = 1'b0;
    chk("R9 power-down leaves mode", longint'(burst_active), 0);
    chk("R9 power-down drops word", longint'(word_vld), 0);

    // R9: hardware reset
    enable_burst();
    run_burst(1000, 40, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R9 reset leaves mode", longint'(burst_active), 0);
    chk("R9 reset drops word", longint'(word_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 mode off after reset", longint'(burst_active), 0);
    enable_burst();
    run_burst(1023, 2, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule